// File: doc/BRIEF.md
# USB Host Controller Status and Interrupt Register

This block holds the 32-bit status word of a USB host controller. Software reads it and clears event bits over a simple register bus: a decoded select, a write enable, write data and registered read data. The controller core feeds it strobes for transfer completion, transfer errors, port changes, async-advance events and host system errors. It also feeds the run/stop command bit, the two schedule enables, the frame index and the frame list size.

The block keeps six sticky event flags that software clears by writing ones to them. It also keeps two schedule status bits, a reclamation bit and a halted bit. It watches the frame index for rollover, with the watched bit chosen by the frame list size, and detects rising edges on per-port change and resume bits. It drives a registered interrupt line, which is the OR of the enabled flags, and a one-cycle request to clear run/stop whenever a host system error is reported.

Top module: `usbh_status_reg`

## Requirements
- R1: Read data is registered. On the cycle after a read (select high, write low), `reg_rdata` holds the status word as it stood before that clock edge. In every other case it is zero. Bits 31:16 and 11:6 are always zero.
- R2: Bit 15 (async schedule status) and bit 14 (periodic schedule status) reset to 0. They take the values of `async_en` and `per_en` only on a cycle with `frame_tick` high, and hold otherwise.
- R3: Bit 13 is a registered copy of `reclaim_in` and resets to 0.
- R4: Bit 12 (halted) resets to 1. It is 0 after any cycle in which `run_stop` is 1. It becomes 1 only after a cycle in which `run_stop` is 0 and `core_idle` is 1, and otherwise holds.
- R5: Event bits 5:0 reset to 0. Writing a 1 to bit i clears bit i, and writing a 0 leaves it unchanged. A hardware set in the same cycle as a clear leaves the bit at 1.
- R6: Bit 5 sets on `async_adv_ev`. Bit 4 sets on `host_err_ev`, and `rs_clear` is high for exactly the cycle after each cycle in which `host_err_ev` is high.
- R7: Bit 3 sets when the watched frame index bit differs from its value in the previous cycle, in either direction. The watched bit is 13 for `fl_size`=0 (1024 entries), 12 for `fl_size`=1 (512 entries) and 11 for `fl_size`=2 or 3 (256 entries). No rollover is detected on the first cycle after reset.
- R8: Bit 2 sets when a port with `port_owner` 0 shows a 0-to-1 edge on its `port_chg` or `port_resume` bit. Both edges are taken against the previous cycle, and the previous values reset to 0. Such edges on ports with owner 1 have no effect. Bit 2 also sets on any `port_handoff_csc` bit, whatever the owner.
- R9: When `xfer_done` is high, bit 0 sets if `xfer_ioc` or `xfer_short` is high, and bit 1 sets if `xfer_err` is high. An errored completion with IOC sets both. Nothing is set while `xfer_done` is low.
- R10: `irq` is 1 on the cycle after a cycle in which any bit of (bits 5:0 AND `irq_mask`) is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select from the address decode |
| reg_wr | input | 1 | Write enable, qualified by reg_sel |
| reg_wdata | input | DATA_W | Write data, where ones clear event bits |
| reg_rdata | output | DATA_W | Registered read data |
| run_stop | input | 1 | Run/stop bit from the command register |
| core_idle | input | 1 | Controller core has stopped executing |
| async_en | input | 1 | Async schedule enable |
| per_en | input | 1 | Periodic schedule enable |
| frame_tick | input | 1 | Frame boundary strobe |
| reclaim_in | input | 1 | Reclamation state from the schedule walker |
| frame_index | input | FIDX_W | Current frame index |
| fl_size | input | 2 | Frame list size code |
| port_chg | input | NPORT | Per-port change bits (OR of change bits) |
| port_resume | input | NPORT | Per-port force-resume bits |
| port_owner | input | NPORT | Per-port owner bit (1 = handed away) |
| port_handoff_csc | input | NPORT | Connect change after handoff strobes |
| async_adv_ev | input | 1 | Async schedule advanced after doorbell |
| host_err_ev | input | 1 | Host system access error strobe |
| xfer_done | input | 1 | Transfer descriptor retired |
| xfer_ioc | input | 1 | Retired descriptor had IOC |
| xfer_err | input | 1 | Retired descriptor ended in error |
| xfer_short | input | 1 | Short packet received |
| irq_mask | input | 6 | Interrupt enable mask for bits 5:0 |
| irq | output | 1 | Registered interrupt request |
| rs_clear | output | 1 | Request to clear run/stop |

## Verification
The hardest case to reach from the ports is a hardware set and a software clear landing on the same flag in the same cycle. The bench drives an event strobe in the same cycle as a write-one to that bit, and also runs a random phase in which strobes and random write masks collide often. Rollover is hard to reach by counting, so the bench jumps the frame index straight across each watched bit, in both directions, under every size code. It also changes the size code while the index is steady, which exposes a detector that compares the wrong bit. A behavioural model steps with every clock, so each collision is checked in the cycle it lands.

// File: rtl/usbh_sts_pkg.sv
package usbh_sts_pkg;
  localparam int NUM_EVT  = 6;
  localparam int EV_XFER  = 0;
  localparam int EV_XERR  = 1;
  localparam int EV_PORT  = 2;
  localparam int EV_ROLL  = 3;
  localparam int EV_HSE   = 4;
  localparam int EV_AADV  = 5;

  localparam int POS_HALT = 12;
  localparam int POS_RECL = 13;
  localparam int POS_PER  = 14;
  localparam int POS_ASYNC = 15;

  typedef enum logic [1:0] {
    FL_1024 = 2'd0,
    FL_512  = 2'd1,
    FL_256  = 2'd2,
    FL_RSVD = 2'd3
  } fl_size_e;
endpackage

// File: rtl/usbh_sched_track.sv
module usbh_sched_track (
  input  logic clk,
  input  logic rst,
  input  logic run_stop,
  input  logic core_idle,
  input  logic async_en,
  input  logic per_en,
  input  logic frame_tick,
  input  logic reclaim_in,
  output logic async_sts,
  output logic per_sts,
  output logic reclaim_sts,
  output logic halted
);
  // Schedule status follows its enable only at frame boundaries.
  always_ff @(posedge clk) begin
    if (rst) begin
      async_sts <= 1'b0;
      per_sts   <= 1'b0;
    end else if (frame_tick) begin
      async_sts <= async_en;
      per_sts   <= per_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reclaim_sts <= 1'b0;
    else     reclaim_sts <= reclaim_in;
  end

  // Halted drops as soon as run is requested, rises once the core is idle.
  always_ff @(posedge clk) begin
    if (rst)            halted <= 1'b1;
    else if (run_stop)  halted <= 1'b0;
    else if (core_idle) halted <= 1'b1;
  end
endmodule

// File: rtl/usbh_rollover_det.sv
module usbh_rollover_det #(
  parameter int FIDX_W = 14,
  parameter int NSIZE  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FIDX_W-1:0] frame_index,
  input  logic [1:0]        fl_size,
  output logic              rollover
);
  localparam int LO = FIDX_W - NSIZE;

  logic [NSIZE-1:0] prev_top;
  logic [NSIZE-1:0] toggled;
  logic             prev_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_top <= '0;
      prev_vld <= 1'b0;
    end else begin
      prev_top <= frame_index[FIDX_W-1:LO];
      prev_vld <= 1'b1;
    end
  end

  // One toggle detector per candidate bit; index 0 is the smallest list.
  for (genvar g = 0; g < NSIZE; g++) begin : g_tog
    assign toggled[g] = frame_index[LO+g] ^ prev_top[g];
  end

  // Size code s watches bit FIDX_W-1-s; codes past the table use the smallest.
  always_comb begin
    rollover = toggled[0];
    for (int s = 0; s < NSIZE; s++) begin
      if (32'(fl_size) == 32'(s)) rollover = toggled[NSIZE-1-s];
    end
    rollover = rollover & prev_vld;
  end
endmodule

// File: rtl/usbh_port_edge.sv
module usbh_port_edge #(
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] chg,
  input  logic [NPORT-1:0] res,
  input  logic [NPORT-1:0] owner,
  input  logic [NPORT-1:0] handoff_csc,
  output logic             port_event
);
  logic [NPORT-1:0] chg_q;
  logic [NPORT-1:0] res_q;
  logic [NPORT-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_q <= '0;
      res_q <= '0;
    end else begin
      chg_q <= chg;
      res_q <= res;
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign hit[g] = (~owner[g] & ((chg[g] & ~chg_q[g]) | (res[g] & ~res_q[g])))
                  | handoff_csc[g];
  end

  assign port_event = |hit;
endmodule

// File: rtl/usbh_event_flags.sv
module usbh_event_flags #(
  parameter int NUM = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] set,
  input  logic [NUM-1:0] clr,
  output logic [NUM-1:0] flags
);
  for (genvar g = 0; g < NUM; g++) begin : g_bit
    logic f_q;
    // Hardware set takes priority over a same-cycle software clear.
    always_ff @(posedge clk) begin
      if (rst)         f_q <= 1'b0;
      else if (set[g]) f_q <= 1'b1;
      else if (clr[g]) f_q <= 1'b0;
    end
    assign flags[g] = f_q;
  end
endmodule

// File: rtl/usbh_status_reg.sv
module usbh_status_reg
  import usbh_sts_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NPORT  = 2,
  parameter int FIDX_W = 14,
  parameter int NSIZE  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               run_stop,
  input  logic               core_idle,
  input  logic               async_en,
  input  logic               per_en,
  input  logic               frame_tick,
  input  logic               reclaim_in,
  input  logic [FIDX_W-1:0]  frame_index,
  input  logic [1:0]         fl_size,
  input  logic [NPORT-1:0]   port_chg,
  input  logic [NPORT-1:0]   port_resume,
  input  logic [NPORT-1:0]   port_owner,
  input  logic [NPORT-1:0]   port_handoff_csc,
  input  logic               async_adv_ev,
  input  logic               host_err_ev,
  input  logic               xfer_done,
  input  logic               xfer_ioc,
  input  logic               xfer_err,
  input  logic               xfer_short,
  input  logic [NUM_EVT-1:0] irq_mask,
  output logic               irq,
  output logic               rs_clear
);
  logic               async_sts, per_sts, reclaim_sts, halted;
  logic               rollover, port_event;
  logic [NUM_EVT-1:0] evt_set, evt_clr, flags;
  logic [DATA_W-1:0]  status;
  logic               rd_en;

  usbh_sched_track u_sched (
    .clk         (clk),
    .rst         (rst),
    .run_stop    (run_stop),
    .core_idle   (core_idle),
    .async_en    (async_en),
    .per_en      (per_en),
    .frame_tick  (frame_tick),
    .reclaim_in  (reclaim_in),
    .async_sts   (async_sts),
    .per_sts     (per_sts),
    .reclaim_sts (reclaim_sts),
    .halted      (halted)
  );

  usbh_rollover_det #(.FIDX_W(FIDX_W), .NSIZE(NSIZE)) u_roll (
    .clk         (clk),
    .rst         (rst),
    .frame_index (frame_index),
    .fl_size     (fl_size),
    .rollover    (rollover)
  );

  usbh_port_edge #(.NPORT(NPORT)) u_port (
    .clk         (clk),
    .rst         (rst),
    .chg         (port_chg),
    .res         (port_resume),
    .owner       (port_owner),
    .handoff_csc (port_handoff_csc),
    .port_event  (port_event)
  );

  always_comb begin
    evt_set          = '0;
    evt_set[EV_XFER] = xfer_done & (xfer_ioc | xfer_short);
    evt_set[EV_XERR] = xfer_done & xfer_err;
    evt_set[EV_PORT] = port_event;
    evt_set[EV_ROLL] = rollover;
    evt_set[EV_HSE]  = host_err_ev;
    evt_set[EV_AADV] = async_adv_ev;
  end

  assign evt_clr = (reg_sel & reg_wr) ? reg_wdata[NUM_EVT-1:0] : '0;

  usbh_event_flags #(.NUM(NUM_EVT)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set   (evt_set),
    .clr   (evt_clr),
    .flags (flags)
  );

  always_comb begin
    status                = '0;
    status[POS_ASYNC]     = async_sts;
    status[POS_PER]       = per_sts;
    status[POS_RECL]      = reclaim_sts;
    status[POS_HALT]      = halted;
    status[NUM_EVT-1:0]   = flags;
  end

  assign rd_en = reg_sel & ~reg_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
      rs_clear  <= 1'b0;
    end else begin
      reg_rdata <= rd_en ? status : '0;
      irq       <= |(flags & irq_mask);
      rs_clear  <= host_err_ev;
    end
  end
endmodule

// File: rtl/usbh_status_chk.sv
module usbh_status_chk
  import usbh_sts_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               run_stop,
  input logic               host_err_ev,
  input logic               async_adv_ev,
  input logic               frame_tick,
  input logic               halted,
  input logic [1:0]         sched_sts,
  input logic [NUM_EVT-1:0] flags,
  input logic [NUM_EVT-1:0] irq_mask,
  input logic               irq,
  input logic               rs_clear
);
  // R1
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[DATA_W-1:16] == '0) && (reg_rdata[11:6] == '0));

  // R2
  sched_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(sched_sts));

  // R4
  halt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    run_stop |=> !halted);

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    async_adv_ev |=> flags[EV_AADV]);

  // R6
  hse_stop_chk: assert property (@(posedge clk) disable iff (rst)
    host_err_ev |=> (flags[EV_HSE] && rs_clear));

  // R6
  rs_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !host_err_ev |=> !rs_clear);

  // R10
  irq_on_chk: assert property (@(posedge clk) disable iff (rst)
    (|(flags & irq_mask)) |=> irq);

  // R10
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & irq_mask)) |=> !irq);
endmodule

bind usbh_status_reg usbh_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_rdata    (reg_rdata),
  .run_stop     (run_stop),
  .host_err_ev  (host_err_ev),
  .async_adv_ev (async_adv_ev),
  .frame_tick   (frame_tick),
  .halted       (halted),
  .sched_sts    ({async_sts, per_sts}),
  .flags        (flags),
  .irq_mask     (irq_mask),
  .irq          (irq),
  .rs_clear     (rs_clear)
);

// File: tb/usbh_status_reg_tb.sv
`timescale 1ns/1ps
module usbh_status_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_sel = 1'b1, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        run_stop = 0, core_idle = 0, async_en = 0, per_en = 0;
  logic        frame_tick = 0, reclaim_in = 0;
  logic [13:0] frame_index = '0;
  logic [1:0]  fl_size = '0;
  logic [1:0]  port_chg = '0, port_resume = '0, port_owner = '0, port_handoff_csc = '0;
  logic        async_adv_ev = 0, host_err_ev = 0;
  logic        xfer_done = 0, xfer_ioc = 0, xfer_err = 0, xfer_short = 0;
  logic [5:0]  irq_mask = '0;
  logic        irq, rs_clear;

  always #4 clk = ~clk;

  usbh_status_reg u_dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .run_stop(run_stop),
    .core_idle(core_idle), .async_en(async_en), .per_en(per_en),
    .frame_tick(frame_tick), .reclaim_in(reclaim_in),
    .frame_index(frame_index), .fl_size(fl_size), .port_chg(port_chg),
    .port_resume(port_resume), .port_owner(port_owner),
    .port_handoff_csc(port_handoff_csc), .async_adv_ev(async_adv_ev),
    .host_err_ev(host_err_ev), .xfer_done(xfer_done), .xfer_ioc(xfer_ioc),
    .xfer_err(xfer_err), .xfer_short(xfer_short), .irq_mask(irq_mask),
    .irq(irq), .rs_clear(rs_clear)
  );

  // Behavioural reference state
  logic [5:0]  m_flags;
  logic        m_halt, m_as, m_ps, m_recl, m_irq, m_rs, m_pvld;
  logic [31:0] m_rdata;
  logic [13:0] m_pfidx;
  logic [1:0]  m_pchg, m_pres;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string flag_tag [6] = '{"R9 ioc/short", "R9 error", "R8 port", "R7 rollover",
                          "R6 host error", "R6 async advance"};

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [31:0] snap;
    logic        roll, port;
    logic [5:0]  sets;
    int          bp;
    if (rst) begin
      m_flags = '0; m_halt = 1; m_as = 0; m_ps = 0; m_recl = 0;
      m_irq = 0; m_rs = 0; m_rdata = '0; m_pvld = 0; m_pfidx = '0;
      m_pchg = '0; m_pres = '0;
      return;
    end
    snap = '0;
    snap[15] = m_as; snap[14] = m_ps; snap[13] = m_recl; snap[12] = m_halt;
    snap[5:0] = m_flags;
    m_rdata = (reg_sel && !reg_wr) ? snap : 32'h0;
    m_irq = |(m_flags & irq_mask);
    m_rs = host_err_ev;
    bp = (fl_size == 2'd0) ? 13 : (fl_size == 2'd1) ? 12 : 11;
    roll = m_pvld && (frame_index[bp] != m_pfidx[bp]);
    port = 0;
    for (int p = 0; p < 2; p++) begin
      if (!port_owner[p] && ((port_chg[p] && !m_pchg[p]) || (port_resume[p] && !m_pres[p])))
        port = 1;
      if (port_handoff_csc[p]) port = 1;
    end
    sets = {async_adv_ev, host_err_ev, roll, port, xfer_done && xfer_err,
            xfer_done && (xfer_ioc || xfer_short)};
    for (int i = 0; i < 6; i++) begin
      if (sets[i]) m_flags[i] = 1'b1;
      else if (reg_sel && reg_wr && reg_wdata[i]) m_flags[i] = 1'b0;
    end
    if (frame_tick) begin m_as = async_en; m_ps = per_en; end
    m_recl = reclaim_in;
    if (run_stop) m_halt = 0; else if (core_idle) m_halt = 1;
    m_pfidx = frame_index; m_pvld = 1; m_pchg = port_chg; m_pres = port_resume;
  endtask

  // One clock: step the model for the edge just passed, then compare.
  task automatic tick();
    @(negedge clk);
    model_step();
    check(reg_rdata[31:16] == 16'h0 && reg_rdata[11:6] == 6'h0, "R1 unused bits",
          reg_rdata, m_rdata & 32'h0000_F03F);
    check(reg_rdata[15:14] == m_rdata[15:14], "R2 sched status",
          {30'h0, reg_rdata[15:14]}, {30'h0, m_rdata[15:14]});
    check(reg_rdata[13] == m_rdata[13], "R3 reclamation", {31'h0, reg_rdata[13]},
          {31'h0, m_rdata[13]});
    check(reg_rdata[12] == m_rdata[12], "R4 halted", {31'h0, reg_rdata[12]},
          {31'h0, m_rdata[12]});
    for (int i = 0; i < 6; i++)
      check(reg_rdata[i] == m_rdata[i], {"R5 ", flag_tag[i]}, {31'h0, reg_rdata[i]},
            {31'h0, m_rdata[i]});
    check(irq == m_irq, "R10 irq", {31'h0, irq}, {31'h0, m_irq});
    check(rs_clear == m_rs, "R6 rs_clear", {31'h0, rs_clear}, {31'h0, m_rs});
  endtask

  task automatic clear_bits(input logic [5:0] m);
    reg_wr = 1; reg_wdata = {26'h0, m}; tick(); reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic set_fidx(input logic [13:0] v);
    frame_index = v; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R4 reset value: only halted reads as one
    check(reg_rdata == 32'h0000_1000, "R4 reset word", reg_rdata, 32'h0000_1000);
    check(irq == 1'b0, "R10 reset irq", {31'h0, irq}, 32'h0);

    // R4 run clears halted
    run_stop = 1; repeat (2) tick();
    check(reg_rdata[12] == 1'b0, "R4 running", {31'h0, reg_rdata[12]}, 32'h0);

    // R2 enables without a frame boundary do not show, then copy at the tick
    async_en = 1; per_en = 1; repeat (3) tick();
    check(reg_rdata[15:14] == 2'b00, "R2 lag", {30'h0, reg_rdata[15:14]}, 32'h0);
    frame_tick = 1; tick(); frame_tick = 0; tick();
    check(reg_rdata[15:14] == 2'b11, "R2 copied", {30'h0, reg_rdata[15:14]}, 32'h3);
    per_en = 0; repeat (2) tick(); frame_tick = 1; tick(); frame_tick = 0; tick();

    // R3 reclamation follows its input
    reclaim_in = 1; repeat (2) tick(); reclaim_in = 0; repeat (2) tick();

    // R6 / R5 events, interrupt mask and write-one-to-clear
    irq_mask = 6'h3F;
    async_adv_ev = 1; tick(); async_adv_ev = 0; repeat (2) tick();
    host_err_ev = 1; tick(); host_err_ev = 0; repeat (2) tick();
    check(reg_rdata[5:4] == 2'b11, "R6 flags set", {30'h0, reg_rdata[5:4]}, 32'h3);
    clear_bits(6'b010000); repeat (2) tick();
    // R5 set and clear collide: set wins
    async_adv_ev = 1; clear_bits(6'b100000); async_adv_ev = 0; repeat (2) tick();
    check(reg_rdata[5] == 1'b1, "R5 set wins", {31'h0, reg_rdata[5]}, 32'h1);
    clear_bits(6'h3F); repeat (3) tick();
    check(irq == 1'b0, "R10 irq cleared", {31'h0, irq}, 32'h0);

    // R7 rollover under every size code, both directions
    fl_size = 2'd0; set_fidx(14'h1FFF); set_fidx(14'h2000); set_fidx(14'h3FFF);
    set_fidx(14'h0000); tick();
    clear_bits(6'h08);
    fl_size = 2'd1; set_fidx(14'h0FFF); set_fidx(14'h1000); tick(); clear_bits(6'h08);
    fl_size = 2'd2; set_fidx(14'h07FF); set_fidx(14'h0800); tick(); clear_bits(6'h08);
    fl_size = 2'd3; set_fidx(14'h0000); tick(); clear_bits(6'h08);
    // R7 size change on a steady index with differing bits
    frame_index = 14'h2000; fl_size = 2'd0; repeat (2) tick(); clear_bits(6'h08);
    fl_size = 2'd2; repeat (2) tick();

    // R8 port edges: owned-away port ignored, local port counted, handoff counted
    port_owner = 2'b01; port_chg = 2'b01; repeat (2) tick();
    check(reg_rdata[2] == 1'b0, "R8 owner ignored", {31'h0, reg_rdata[2]}, 32'h0);
    port_chg = 2'b11; repeat (2) tick(); clear_bits(6'h04);
    port_resume = 2'b10; repeat (2) tick(); clear_bits(6'h04);
    port_chg = '0; port_resume = '0; tick();
    port_handoff_csc = 2'b01; tick(); port_handoff_csc = '0; tick(); clear_bits(6'h04);

    // R9 transfer completions
    xfer_ioc = 1; xfer_err = 1; tick();
    check(reg_rdata[1:0] == 2'b00, "R9 no done", {30'h0, reg_rdata[1:0]}, 32'h0);
    xfer_done = 1; tick(); xfer_done = 0; xfer_ioc = 0; xfer_err = 0; tick();
    check(reg_rdata[1:0] == 2'b11, "R9 err+ioc", {30'h0, reg_rdata[1:0]}, 32'h3);
    clear_bits(6'h03);
    xfer_done = 1; xfer_short = 1; tick(); xfer_done = 0; xfer_short = 0; tick();
    clear_bits(6'h03);

    // R10 masked flag does not interrupt
    irq_mask = 6'h01; async_adv_ev = 1; tick(); async_adv_ev = 0; repeat (2) tick();
    check(irq == 1'b0, "R10 masked", {31'h0, irq}, 32'h0);
    clear_bits(6'h3F);

    // R4 stop: halted waits for idle
    run_stop = 0; repeat (3) tick();
    check(reg_rdata[12] == 1'b0, "R4 not idle", {31'h0, reg_rdata[12]}, 32'h0);
    core_idle = 1; repeat (2) tick();
    check(reg_rdata[12] == 1'b1, "R4 halted", {31'h0, reg_rdata[12]}, 32'h1);

    // R1 no-select and write cycles read zero
    reg_sel = 0; repeat (2) tick(); reg_sel = 1;

    // Random phase with frequent collisions
    for (int n = 0; n < 4000; n++) begin
      reg_sel      = ($urandom_range(0, 7) != 0);
      reg_wr       = ($urandom_range(0, 3) == 0);
      reg_wdata    = $urandom();
      run_stop     = ($urandom_range(0, 15) == 0) ? ~run_stop : run_stop;
      core_idle    = $urandom_range(0, 1);
      async_en     = $urandom_range(0, 1);
      per_en       = $urandom_range(0, 1);
      frame_tick   = ($urandom_range(0, 5) == 0);
      reclaim_in   = $urandom_range(0, 1);
      fl_size      = ($urandom_range(0, 31) == 0) ? 2'($urandom_range(0, 3)) : fl_size;
      frame_index  = frame_index + 14'($urandom_range(0, 600));
      port_chg     = 2'($urandom_range(0, 3));
      port_resume  = 2'($urandom_range(0, 3));
      port_owner   = ($urandom_range(0, 15) == 0) ? 2'($urandom_range(0, 3)) : port_owner;
      port_handoff_csc = ($urandom_range(0, 15) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      async_adv_ev = ($urandom_range(0, 7) == 0);
      host_err_ev  = ($urandom_range(0, 11) == 0);
      xfer_done    = ($urandom_range(0, 3) == 0);
      xfer_ioc     = $urandom_range(0, 1);
      xfer_err     = ($urandom_range(0, 3) == 0);
      xfer_short   = ($urandom_range(0, 3) == 0);
      irq_mask     = ($urandom_range(0, 31) == 0) ? 6'($urandom()) : irq_mask;
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule